// File: doc/BRIEF.md
# Lockable Always-On Scratch Register

This block keeps one 32-bit scratch word on the always-on power domain. Software reaches it, and four control registers beside it, through a single-cycle register port. Writes strobe on one clock edge. Reads are combinational from the address.

A scratch write lands only when three conditions all hold:
- the soft lock is clear;
- the hard lock is clear;
- the sticky power-glitch flag is clear.

A write that fails the gate is dropped without any error. After an always-on power-up the glitch flag is set. Software clears it in two steps: first it writes a fixed key into the glitch-detector configuration register, then it writes a 1 to the flag.

The soft lock ends at any system reset. The hard lock, the glitch flag, the configuration register and the scratch word stay as they are until the always-on power-on reset.

Top module: `aon_scratch_reg`

## Requirements
- R1: After an always-on power-on reset, every register reads 0, except the status register at offset 0x4C, which reads 0x00000008 (glitch flag in bit 3 set). The soft lock is at 0x00, the hard lock at 0x34, the detector configuration at 0x64 and the scratch word at 0x90.
- R2: While the glitch flag is set, a write to 0x90 has no effect, and the word keeps reading its previous value.
- R3: Writing 1 to bit 3 of 0x4C clears the flag only when 0x64 holds 0x41736166. Otherwise that write is ignored.
- R4: When the flag and both locks are clear, a write to 0x90 is read back from the next cycle onward.
- R5: Writing any value other than 0x41736166 to 0x64 sets the glitch flag again.
- R6: Writing a 1 to bit 5 of 0x00 sets the soft lock, and the lock then reads back as 0x20. While it is set, scratch writes are dropped. A write of 0 does not clear it; a system reset does.
- R7: Writing a 1 to bit 5 of 0x34 sets the hard lock, and the lock then reads back as 0x20. While it is set, scratch writes are dropped. It survives system reset and clears only on an always-on power-on reset.
- R8: A system reset leaves the scratch word, the configuration register and a cleared flag unchanged. An always-on power-on reset sets the flag again and clears the scratch word.
- R9: Offsets outside the five mapped ones read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | System reset, active low, asynchronous |
| por_ni | input | 1 | Always-on power-on reset, active low, asynchronous |
| wr_en_i | input | 1 | Write strobe for one cycle |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |

## Verification
The assertions take for granted three things about the inputs:
- a write lasts one cycle;
- the address and data are stable at the capturing edge;
- the power-on reset is never released while the system reset is still being asserted in a way that splits the domains mid-cycle.

The stimulus drives every input on the falling edge. It holds the strobe for exactly one cycle and pulses each reset between clock edges. Random data and random unmapped offsets are drawn only inside these rules.

// File: rtl/aon_scratch_pkg.sv
package aon_scratch_pkg;
  localparam int OFF_SOFT_LOCK = 'h00;
  localparam int OFF_HARD_LOCK = 'h34;
  localparam int OFF_STATUS    = 'h4C;
  localparam int OFF_GLITCH    = 'h64;
  localparam int OFF_SCRATCH   = 'h90;
  localparam int LOCK_BIT      = 5;
  localparam int FLAG_BIT      = 3;
  localparam logic [31:0] GLITCH_KEY = 32'h41736166;
endpackage

// File: rtl/aon_lock_ctrl.sv
module aon_lock_ctrl (
  input  logic clk_i,
  input  logic sys_rst_ni,
  input  logic por_ni,
  input  logic soft_set_i,
  input  logic hard_set_i,
  output logic soft_o,
  output logic hard_o
);
  logic soft_q, hard_q;

  always_ff @(posedge clk_i or negedge sys_rst_ni) begin
    if (!sys_rst_ni)     soft_q <= 1'b0;
    else if (soft_set_i) soft_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni)         hard_q <= 1'b0;
    else if (hard_set_i) hard_q <= 1'b1;
  end

  assign soft_o = soft_q;
  assign hard_o = hard_q;

  AST_SOFT_STICKY: assert property (@(posedge clk_i) disable iff (!sys_rst_ni)
    soft_q |=> soft_q); // R6
  AST_HARD_STICKY: assert property (@(posedge clk_i) disable iff (!por_ni)
    hard_q |=> hard_q); // R7
endmodule

// File: rtl/aon_glitch_mon.sv
module aon_glitch_mon #(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] KEY = '0
) (
  input  logic              clk_i,
  input  logic              por_ni,
  input  logic              cfg_we_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  input  logic              clr_i,
  output logic [DATA_W-1:0] cfg_o,
  output logic              flag_o
);
  logic [DATA_W-1:0] cfg_q;
  logic              flag_q;
  logic              key_ok;

  assign key_ok = (cfg_q == KEY);

  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) begin
      cfg_q  <= '0;
      flag_q <= 1'b1;
    end else begin
      if (cfg_we_i) begin
        cfg_q <= cfg_wdata_i;
        if (cfg_wdata_i != KEY) flag_q <= 1'b1;
      end else if (clr_i && key_ok) begin
        flag_q <= 1'b0;
      end
    end
  end

  assign cfg_o  = cfg_q;
  assign flag_o = flag_q;

  AST_FLAG_NEEDS_KEY: assert property (@(posedge clk_i) disable iff (!por_ni)
    $fell(flag_q) |-> ($past(cfg_q) == KEY)); // R3
  AST_BADKEY_REARMS: assert property (@(posedge clk_i) disable iff (!por_ni)
    (cfg_we_i && cfg_wdata_i != KEY) |=> flag_q); // R5
endmodule

// File: rtl/aon_scratch_word.sv
module aon_scratch_word #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              por_ni,
  input  logic              we_i,
  input  logic              ok_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] q_o
);
  logic [DATA_W-1:0] q;

  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni)          q <= '0;
    else if (we_i && ok_i) q <= wdata_i;
  end

  assign q_o = q;

  AST_BLOCKED_HOLDS: assert property (@(posedge clk_i) disable iff (!por_ni)
    (we_i && !ok_i) |=> $stable(q)); // R2
endmodule

// File: rtl/aon_scratch_reg.sv
module aon_scratch_reg
  import aon_scratch_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [ADDR_W-1:0] A_SOFT = ADDR_W'(OFF_SOFT_LOCK);
  localparam logic [ADDR_W-1:0] A_HARD = ADDR_W'(OFF_HARD_LOCK);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STATUS);
  localparam logic [ADDR_W-1:0] A_GLIT = ADDR_W'(OFF_GLITCH);
  localparam logic [ADDR_W-1:0] A_SCR  = ADDR_W'(OFF_SCRATCH);

  logic              sys_rst_n;
  logic              soft_lock, hard_lock, glitch_flag, scr_ok;
  logic [DATA_W-1:0] cfg_val, scr_val;
  logic              wr_soft, wr_hard, wr_stat, wr_glit, wr_scr;

  // soft domain also drops on always-on power-up
  assign sys_rst_n = rst_ni & por_ni;

  assign wr_soft = wr_en_i && (addr_i == A_SOFT);
  assign wr_hard = wr_en_i && (addr_i == A_HARD);
  assign wr_stat = wr_en_i && (addr_i == A_STAT);
  assign wr_glit = wr_en_i && (addr_i == A_GLIT);
  assign wr_scr  = wr_en_i && (addr_i == A_SCR);

  aon_lock_ctrl u_lock (
    .clk_i      (clk_i),
    .sys_rst_ni (sys_rst_n),
    .por_ni     (por_ni),
    .soft_set_i (wr_soft && wdata_i[LOCK_BIT]),
    .hard_set_i (wr_hard && wdata_i[LOCK_BIT]),
    .soft_o     (soft_lock),
    .hard_o     (hard_lock)
  );

  aon_glitch_mon #(.DATA_W(DATA_W), .KEY(DATA_W'(GLITCH_KEY))) u_glitch (
    .clk_i       (clk_i),
    .por_ni      (por_ni),
    .cfg_we_i    (wr_glit),
    .cfg_wdata_i (wdata_i),
    .clr_i       (wr_stat && wdata_i[FLAG_BIT]),
    .cfg_o       (cfg_val),
    .flag_o      (glitch_flag)
  );

  assign scr_ok = !soft_lock && !hard_lock && !glitch_flag;

  aon_scratch_word #(.DATA_W(DATA_W)) u_word (
    .clk_i   (clk_i),
    .por_ni  (por_ni),
    .we_i    (wr_scr),
    .ok_i    (scr_ok),
    .wdata_i (wdata_i),
    .q_o     (scr_val)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_SOFT: rdata_o[LOCK_BIT] = soft_lock;
      A_HARD: rdata_o[LOCK_BIT] = hard_lock;
      A_STAT: rdata_o[FLAG_BIT] = glitch_flag;
      A_GLIT: rdata_o = cfg_val;
      A_SCR:  rdata_o = scr_val;
      default: rdata_o = '0;
    endcase
  end

  AST_LOCKED_NO_WRITE: assert property (@(posedge clk_i) disable iff (!por_ni)
    (wr_scr && (soft_lock || hard_lock)) |=> $stable(scr_val)); // R6
  AST_SYSRST_KEEPS_AON: assert property (@(posedge clk_i) disable iff (!por_ni)
    (!glitch_flag && !wr_glit) |=> !glitch_flag); // R8
endmodule

// File: tb/aon_scratch_reg_bench.sv
module aon_scratch_reg_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        por_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  int total = 0;
  int bad = 0;
  bit done = 0;

  // bench-side model
  bit          m_soft, m_hard, m_flag;
  logic [31:0] m_scr, m_cfg;

  localparam logic [31:0] KEY = 32'h41736166;

  always #2.5 clk = ~clk;

  aon_scratch_reg u_aon_scratch_reg (
    .clk_i(clk), .rst_ni(rst_n), .por_ni(por_n), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
  );

  function automatic bit is_mapped(logic [7:0] a);
    return a == 8'h00 || a == 8'h34 || a == 8'h4C || a == 8'h64 || a == 8'h90;
  endfunction

  function automatic bit scr_accepts();
    return !m_soft && !m_hard && !m_flag;
  endfunction

  function automatic logic [31:0] exp_read(logic [7:0] a);
    case (a)
      8'h00:   return {26'b0, m_soft, 5'b0};
      8'h34:   return {26'b0, m_hard, 5'b0};
      8'h4C:   return {28'b0, m_flag, 3'b0};
      8'h64:   return m_cfg;
      8'h90:   return m_scr;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd_chk(string req, logic [7:0] a);
    @(negedge clk);
    addr = a;
    #1;
    chk(req, rdata, exp_read(a));
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    case (a)
      8'h00: if (d[5]) m_soft = 1;
      8'h34: if (d[5]) m_hard = 1;
      8'h4C: if (d[3] && m_cfg == KEY) m_flag = 0;
      8'h64: begin m_cfg = d; if (d != KEY) m_flag = 1; end
      8'h90: if (scr_accepts()) m_scr = d;
      default: ;
    endcase
  endtask

  task automatic sys_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    m_soft = 0;
  endtask

  task automatic power_cycle();
    @(negedge clk); por_n = 1'b0; rst_n = 1'b0;
    @(negedge clk); por_n = 1'b1; rst_n = 1'b1;
    m_soft = 0; m_hard = 0; m_flag = 1; m_scr = '0; m_cfg = '0;
  endtask

  task automatic unlock();
    wr(8'h64, KEY);
    wr(8'h4C, 32'h8);
  endtask

  initial begin
    void'($urandom(32'd1234));
    power_cycle();
    // R1 reset state at every offset
    rd_chk("R1", 8'h00); rd_chk("R1", 8'h34); rd_chk("R1", 8'h4C);
    rd_chk("R1", 8'h64); rd_chk("R1", 8'h90);
    chk("R1", {28'b0, m_flag, 3'b0}, 32'h8);

    // R2 write dropped while flag set
    wr(8'h90, 32'h12345678); rd_chk("R2", 8'h90);
    // R3 clear without key ignored, wrong key ignored
    wr(8'h4C, 32'h8); rd_chk("R3", 8'h4C);
    wr(8'h64, 32'h41736165); wr(8'h4C, 32'hFFFF_FFFF); rd_chk("R3", 8'h4C);
    // R3 key then clear
    unlock(); rd_chk("R3", 8'h4C); rd_chk("R3", 8'h64);
    // R4 accepted
    wr(8'h90, 32'h12345678); rd_chk("R4", 8'h90);

    // R4/R9 random mix
    for (int i = 0; i < 40; i++) begin
      logic [7:0] ua;
      wr(8'h90, $urandom());
      rd_chk("R4", 8'h90);
      ua = 8'($urandom());
      if (!is_mapped(ua)) begin
        wr(ua, $urandom());
        rd_chk("R9", ua); rd_chk("R9", 8'h90); rd_chk("R9", 8'h64); rd_chk("R9", 8'h4C);
      end
    end

    // R5 overwrite key re-arms flag
    wr(8'h64, 32'h0); rd_chk("R5", 8'h4C);
    wr(8'h90, 32'hDEAD0001); rd_chk("R2", 8'h90);
    unlock(); rd_chk("R5", 8'h4C);

    // R6 soft lock
    wr(8'h00, 32'h20); rd_chk("R6", 8'h00);
    wr(8'h90, 32'hDEAD0002); rd_chk("R6", 8'h90);
    wr(8'h00, 32'h0); rd_chk("R6", 8'h00);
    sys_reset(); rd_chk("R6", 8'h00);
    rd_chk("R8", 8'h90); rd_chk("R8", 8'h4C); rd_chk("R8", 8'h64);
    wr(8'h90, 32'hCAFE0003); rd_chk("R6", 8'h90);

    // R7 hard lock
    wr(8'h34, 32'h20); rd_chk("R7", 8'h34);
    wr(8'h90, 32'hDEAD0004); rd_chk("R7", 8'h90);
    sys_reset(); rd_chk("R7", 8'h34);
    wr(8'h90, 32'hDEAD0005); rd_chk("R7", 8'h90);

    // R8 power cycle restores flag, clears lock and word
    power_cycle();
    rd_chk("R8", 8'h4C); rd_chk("R7", 8'h34); rd_chk("R8", 8'h90);
    wr(8'h90, 32'hDEAD0006); rd_chk("R2", 8'h90);
    unlock(); wr(8'h90, 32'h5A5A5A5A); rd_chk("R4", 8'h90);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule